// File: doc/BRIEF.md
# Instruction-Framed Serial Register Port

This block is a serial slave placed in front of a sixteen-entry register file. A host frames every access with one instruction byte that names a register and a direction. A run of data bytes follows, and its length comes from the register's address, so host and port agree on where each transfer ends without any length field. Serial data is taken on rising edges of the serial clock. Read data is launched on falling edges, so it is stable when the host samples it.

All serial inputs are brought into the system clock domain through synchronisers and sampled there. Register 7 holds the two format bits. One sets the bit order and the other chooses between a shared data pin and a separate output pin. A write that lands on these bits changes the format from the next byte on, even inside the same transfer. A separate resync input, active high, abandons whatever transfer is running and re-arms the port for an instruction, and it leaves registers alone. Chip select high clears only the bit position.

Top module: `serial_regport`

## Requirements
- R1: The instruction byte selects a read when bit 7 is 1 and a write when it is 0. Bits 3:0 select the register. Bits 6:4 have no effect on the transfer.
- R2: The register at address A holds A[1:0]+1 bytes. Exactly that many data bytes follow the instruction. The next 8 rising edges form a new instruction, even when the host meant them as more data.
- R3: Data is captured on rising serial-clock edges. A data byte is written to its register when its 8th bit arrives. A partial byte is never written.
- R4: With format bit 0 clear (the reset state), every byte is shifted most significant bit first, and data bytes go from the register's most significant byte down to byte 0.
- R5: With format bit 0 set, every byte is shifted least significant bit first, and data bytes go from byte 0 upward.
- R6: The format bits are bits 1:0 of register 7. A committed write to them governs every later byte, including the remaining bytes of the same transfer.
- R7: In a read, the output bit changes only on falling serial-clock edges. With format bit 1 clear, read data appears on `sdio_out`, and `sdio_oe` is high during the read data phase and at no other time.
- R8: With format bit 1 set, read data appears on `sdo`, and `sdio_oe` stays low. `sdo` is low outside a read data phase.
- R9: While `resync` is high, the port drops the current transfer and ignores serial-clock edges. The first 8 edges after `resync` falls form an instruction. Bytes committed earlier are kept.
- R10: While `cs_n` is high, serial-clock edges are ignored and the bit position is cleared, so a partly shifted byte is discarded.
- R11: After reset, every register reads zero, the format is most-significant-first with a shared data pin, and `sdio_oe` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| resync | input | 1 | Active-high framing reset |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo | output | 1 | Read data on the separate output pin (format bit 1 set) |

## Verification
The assertions are checked on every system clock cycle. They cover these points: resync leaves the framing at an instruction boundary, chip select clears the bit position, commits line up with byte boundaries, no data byte index goes past the addressed register's width, the read output moves only after a falling edge, and a commit to register 7 reaches the format bits on the next cycle. Only the bench scenarios can show the end-to-end results: the values read back after each write across all four formats, the framing slip when the host sends too many bytes, the format switch in the middle of a transfer, and the bytes that survive a resync.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = MAX_BYTES * 8;
  localparam int BIDX_W    = $clog2(MAX_BYTES);
  localparam int BITPOS_W  = $clog2(WORD_W);
  localparam int CFG_ADDR  = 7;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  // Index of the final data byte for a register: width in bytes minus one.
  function automatic logic [BIDX_W-1:0] last_byte(input logic [3:0] addr);
    return addr[BIDX_W-1:0];
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BIDX_W-1:0] wr_byte,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic [1:0]        cfg
);
  localparam int NREGS = 1 << ADDR_W;

  wire [NREGS-1:0][WORD_W-1:0] mem_w;

  for (genvar a = 0; a < NREGS; a++) begin : g_reg
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
      if (b <= (a % MAX_BYTES)) begin : g_impl
        logic [7:0] byte_q;
        logic       hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(a)) && (wr_byte == BIDX_W'(b));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   byte_q <= '0;
          else if (hit) byte_q <= wr_data;
        end
        assign mem_w[a][b*8 +: 8] = byte_q;
      end else begin : g_none
        assign mem_w[a][b*8 +: 8] = 8'h00;
      end
    end
  end

  assign rd_word = mem_w[rd_addr];
  assign cfg     = mem_w[CFG_ADDR][1:0];

  AST_CFG_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(CFG_ADDR) && wr_byte == '0) |=> (cfg == $past(wr_data[1:0]))); // R6
  AST_BYTE_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_byte <= wr_addr[BIDX_W-1:0])); // R2
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              resync_s,
  input  logic              din_s,
  input  logic              lsb_first,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [BIDX_W-1:0] wr_byte,
  output logic [7:0]        wr_data,
  output logic              rd_active,
  output logic              out_bit
);
  phase_e              phase_q, phase_d;
  logic [2:0]          bit_q, bit_d;
  logic [BIDX_W-1:0]   byte_q, byte_d;
  logic [7:0]          sh_q, sh_d;
  logic                rd_q, rd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                out_q, out_d;
  logic                sclk_d;

  logic                rise, fall;
  logic [BIDX_W-1:0]   last_idx, reg_byte;
  logic [7:0]          sh_in;
  logic [BITPOS_W-1:0] rd_pos;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign last_idx = last_byte(4'(addr_q));
  assign reg_byte = lsb_first ? byte_q : (last_idx - byte_q);
  assign sh_in    = lsb_first ? {din_s, sh_q[7:1]} : {sh_q[6:0], din_s};
  assign rd_pos   = {reg_byte, (lsb_first ? bit_q : ~bit_q)};

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    out_d   = out_q;
    wr_en   = 1'b0;
    if (resync_s) begin
      phase_d = PH_INSTR;
      bit_d   = '0;
      byte_d  = '0;
      out_d   = 1'b0;
    end else if (cs_n_s) begin
      bit_d = '0;
    end else if (rise) begin
      sh_d  = sh_in;
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (phase_q == PH_INSTR) begin
          rd_d    = sh_in[7];
          addr_d  = sh_in[ADDR_W-1:0];
          phase_d = PH_DATA;
          byte_d  = '0;
        end else begin
          wr_en = ~rd_q;
          if (byte_q == last_idx) begin
            phase_d = PH_INSTR;
            byte_d  = '0;
          end else begin
            byte_d = byte_q + BIDX_W'(1);
          end
        end
      end
    end else if (fall && phase_q == PH_DATA && rd_q) begin
      out_d = rd_word[rd_pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bit_q   <= '0;
      byte_q  <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      out_q   <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      out_q   <= out_d;
      sclk_d  <= sclk_s;
    end
  end

  assign addr      = addr_q;
  assign wr_byte   = reg_byte;
  assign wr_data   = sh_in;
  assign out_bit   = out_q;
  assign rd_active = (phase_q == PH_DATA) & rd_q & ~cs_n_s & ~resync_s;

  AST_RESYNC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    resync_s |=> (phase_q == PH_INSTR && bit_q == 3'd0 && byte_q == '0)); // R9
  AST_CS_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_q == 3'd0)); // R10
  AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bit_q == 3'd0)); // R3
  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (byte_q <= last_idx)); // R2
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (($past(sclk_d) && !$past(sclk_s)) || $past(resync_s))); // R7
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic resync,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo
);
  logic [1:0]          rst_q;
  logic                rst_int_n;
  logic [3:0]          pins_s;
  logic [ADDR_W-1:0]   addr;
  logic                wr_en;
  logic [BIDX_W-1:0]   wr_byte;
  logic [7:0]          wr_data;
  logic [WORD_W-1:0]   rd_word;
  logic [1:0]          cfg;
  logic                rd_active;
  logic                out_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  srp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({sclk, cs_n, resync, sdio_in}),
    .q     (pins_s)
  );

  srp_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sclk_s    (pins_s[3]),
    .cs_n_s    (pins_s[2]),
    .resync_s  (pins_s[1]),
    .din_s     (pins_s[0]),
    .lsb_first (cfg[0]),
    .rd_word   (rd_word),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .wr_data   (wr_data),
    .rd_active (rd_active),
    .out_bit   (out_bit)
  );

  srp_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_byte (wr_byte),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_word (rd_word),
    .cfg     (cfg)
  );

  assign sdio_out = out_bit;
  assign sdio_oe  = rd_active & ~cfg[1];
  assign sdo      = rd_active & cfg[1] & out_bit;
endmodule

// File: tb/serial_regport_tb.sv
module serial_regport_tb;
  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, resync, sdio_in;
  logic sdio_out, sdio_oe, sdo;

  int checks = 0;
  int errors = 0;
  int stray  = 0;
  logic [31:0] model [16];
  logic [31:0] got;

  always #5 clk = ~clk;

  serial_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .resync(resync),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One serial bit: drive data while low, sample outputs just before the rising edge.
  task automatic sbit(input logic d, output logic o, output logic e);
    sdio_in = d;
    repeat (6) @(negedge clk);
    o = model[7][1] ? sdo : sdio_out;
    e = sdio_oe;
    if (!model[7][1] && sdo !== 1'b0) stray++;
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic o, e;
    for (int i = 0; i < 8; i++) begin
      sbit(b[model[7][0] ? i : 7 - i], o, e);
      if (e !== 1'b0) stray++;
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [2:0] junk, input logic [31:0] val);
    int n, rb;
    n = int'(a[1:0]) + 1;
    send_byte({1'b0, junk, a});
    for (int k = 0; k < n; k++) begin
      rb = model[7][0] ? k : n - 1 - k;
      send_byte(val[rb*8 +: 8]);
      model[a][rb*8 +: 8] = val[rb*8 +: 8];
    end
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [2:0] junk, input string req, output logic [31:0] g);
    int n, rb, bp;
    logic o, e;
    bit oe_bad;
    n = int'(a[1:0]) + 1;
    g = '0;
    oe_bad = 0;
    send_byte({1'b1, junk, a});
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        rb = model[7][0] ? k : n - 1 - k;
        bp = rb * 8 + (model[7][0] ? i : 7 - i);
        sbit(1'b0, o, e);
        g[bp] = o;
        if (e !== ~model[7][1]) oe_bad = 1;
      end
    end
    chk(g === model[a] && !oe_bad, req, g, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic o, e;
    for (int i = 0; i < 16; i++) model[i] = '0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; resync = 1'b0; sdio_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdio_oe === 1'b0 && sdo === 1'b0, "R11 outputs idle", {30'd0, sdio_oe, sdo}, 32'd0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);

    // R11: registers read zero in the default MSB-first shared-pin format
    rd_check(4'd5, 3'd0, "R11 reset value reg5", got);
    rd_check(4'd7, 3'd0, "R11 reset value reg7", got);

    // R1 R2 R3 R4 R5 R7 R8: sweep every register in every format
    for (int m = 0; m < 4; m++) begin
      wr_reg(4'd7, 3'd0, 32'h5A00_0000 | 32'(m));
      rd_check(4'd7, 3'd2, "R6 format readback", got);
      for (int a = 0; a < 16; a++) begin
        if (a != 7) wr_reg(4'(a), 3'(a), (32'h9E37_79B9 * 32'(a + 1)) ^ (32'h0101_0101 * 32'(m)));
      end
      for (int a = 0; a < 16; a++) begin
        if (m[0]) rd_check(4'(a), 3'b101, "R5 R1 R8 lsb-first sweep", got);
        else      rd_check(4'(a), 3'b101, "R4 R1 R7 msb-first sweep", got);
      end
    end

    // R6: format switch takes effect within the same transfer
    wr_reg(4'd7, 3'd0, 32'hC300_0001);
    wr_reg(4'd7, 3'd0, 32'h3322_1100);
    rd_check(4'd7, 3'd0, "R6 mid-transfer model", got);
    chk(got === 32'hC322_1100, "R6 mid-transfer value", got, 32'hC322_1100);

    // R2: host sends one byte too many; it becomes the next instruction
    send_byte(8'h01);
    send_byte(8'hAB);
    send_byte(8'hCD);
    model[1][15:0] = 16'hABCD;
    send_byte(8'h04);
    send_byte(8'h5C);
    model[4][7:0] = 8'h5C;
    rd_check(4'd4, 3'd0, "R2 overrun becomes instruction", got);
    chk(got === 32'h0000_005C, "R2 overrun target", got, 32'h5C);
    rd_check(4'd1, 3'd0, "R2 two-byte register", got);

    // R9 R3: resync after one committed byte and a partial one
    send_byte(8'h02);
    send_byte(8'h77);
    model[2][23:16] = 8'h77;
    for (int i = 0; i < 4; i++) sbit(1'b1, o, e);
    resync = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) sbit(i[0], o, e);
    resync = 1'b0;
    repeat (6) @(negedge clk);
    rd_check(4'd2, 3'd0, "R9 R3 resync keeps committed byte", got);
    rd_check(4'd6, 3'd0, "R9 untouched register", got);

    // R10: chip select high clears a partial instruction byte
    for (int i = 0; i < 3; i++) sbit(1'b1, o, e);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 5; i++) sbit(1'b1, o, e);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_check(4'd3, 3'd0, "R10 cs_n clears bit count", got);

    chk(stray == 0, "R7 R8 output quiet outside read data", 32'(stray), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule